// File: doc/BRIEF.md
# Dual-Mode Acquisition Sequencing Controller

This controller runs the data-taking cycle for a group of front-end readout boards. Decoded command pulses start, stop, pause and resume it. It issues one-cycle command strobes to the boards: start acquisition, memory-full, readout and flush. It also exports two status levels, `busy` and `acquiring`, so that several detectors can run in lock-step.

The controller has two cycle variants. The mode is captured only when a start is accepted in `ST_IDLE`.

- **Test-beam (triggered) mode** (`mode_trig`=1): `ST_IDLE` -> `ST_START` -> `ST_ACQ` -> `ST_TRIG` -> `ST_MFULL` -> `ST_READOUT` -> `ST_FLUSH` -> end of cycle. A trigger ends the window, and the front-end chips are flushed afterwards.
- **Collider mode** (`mode_trig`=0): `ST_IDLE` -> `ST_START` -> `ST_ACQ` -> `ST_MFULL` -> `ST_READOUT` -> end of cycle. Only memory-full ends the window. There is no trigger state and no flush.

At the end of a cycle the controller goes to `ST_START` if the loop flag is set, otherwise to `ST_IDLE`. The transitions are:

- A stop command moves any state to `ST_IDLE`.
- `ST_START` moves to `ST_ACQ` once the beam gate is open.
- `ST_TRIG` and `ST_MFULL` each last one cycle.
- `ST_READOUT` waits for `ro_done`.
- `ST_FLUSH` lasts a fixed number of cycles.

With power pulsing enabled, the beam level gates acquisition. Pause freezes the sequencing in collider mode only.

Top module: `acq_seq_ctrl`

## Requirements
- R1: A synchronous `rst` forces `ST_IDLE` and clears the loop and pause flags. While in reset and in the cycle after it, all strobes, `busy` and `acquiring` are 0. After reset, a collider cycle runs without being frozen.
- R2: In triggered mode, the strobes of one cycle arrive in this order: `fe_start` (first cycle of `ST_ACQ`), then `fe_memfull` two cycles after the trigger is sampled, then `fe_readout` one cycle later, then `fe_flush` in the cycle after `ro_done` is sampled.
- R3: In collider mode, `mem_full` in `ST_ACQ` produces `fe_memfull` and then `fe_readout`. `trig_pulse` is ignored, and `fe_flush` is never issued.
- R4: In triggered mode, `mem_full` during `ST_ACQ` is ignored, and `acquiring` stays 1.
- R5: `cmd_start_loop` re-enters `ST_START` after every readout, so a fresh `fe_start` follows. `cmd_start_once` runs one cycle and then parks in `ST_IDLE` with `busy`=0.
- R6: `cmd_stop` returns the controller to `ST_IDLE` (`busy`=0) in the next cycle from any state, and no later strobes follow.
- R7: In collider mode, `cmd_pause` freezes the state: `acquiring` drops to 0, `busy` stays 1, `mem_full` is ignored and no strobe is issued. `cmd_resume` unfreezes it. In triggered mode a pause has no effect.
- R8: When `pp_en`=1, the controller waits in `ST_START` while `beam_on`=0. In `ST_ACQ` with the beam low, `acquiring` is 0 and `trig_pulse` is ignored.
- R9: `mode_trig` is sampled only when a start is accepted in `ST_IDLE`. Changing it mid-cycle has no effect on that cycle.
- R10: `ST_READOUT` is left only when `ro_done`=1 (or on stop/reset).
- R11: `ST_FLUSH` lasts exactly `FLUSH_LEN` (default 16) cycles, counted from the cycle that carries `fe_flush`.
- R12: The four strobes are each one cycle wide and never overlap. `busy`=1 in every non-idle state. `acquiring`=1 only in `ST_ACQ` with the gate open and the controller not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous common reset, active high |
| mode_trig | input | 1 | 1 = triggered test-beam mode, 0 = collider mode |
| pp_en | input | 1 | Power pulsing enable (beam gating) |
| beam_on | input | 1 | Beam present level, active high |
| cmd_start_loop | input | 1 | Start command, looping |
| cmd_start_once | input | 1 | Start command, single cycle |
| cmd_stop | input | 1 | Stop command |
| cmd_pause | input | 1 | Pause collider sequencing |
| cmd_resume | input | 1 | Resume collider sequencing |
| trig_pulse | input | 1 | Conditioned trigger pulse |
| mem_full | input | 1 | Front-end memory full flag |
| ro_done | input | 1 | Readout complete flag |
| fe_start | output | 1 | Start-acquisition strobe |
| fe_memfull | output | 1 | Memory-full strobe |
| fe_readout | output | 1 | Readout strobe |
| fe_flush | output | 1 | Chip flush strobe |
| busy | output | 1 | Controller not idle |
| acquiring | output | 1 | Acquisition window open |

## Verification
A wrong state shows at the ports within one or two cycles. A stuck or skipped state gives a missing strobe, an extra strobe or a reordered strobe, and the scoreboard catches this on the next strobe or at the final queue check. A wrong mode capture or pause flag shows as `acquiring` at the wrong level, or as a flush where none belongs. A flush counter that is off by one changes the number of cycles `busy` stays high after `fe_flush`.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_ACQ     = 3'd2,
        ST_TRIG    = 3'd3,
        ST_MFULL   = 3'd4,
        ST_READOUT = 3'd5,
        ST_FLUSH   = 3'd6
    } acq_state_t;

    typedef enum logic {
        MODE_COLLIDER  = 1'b0,
        MODE_TRIGGERED = 1'b1
    } acq_mode_t;

endpackage

// File: rtl/acq_flush_timer.sv
module acq_flush_timer #(
    parameter int FLUSH_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = (FLUSH_LEN > 2) ? $clog2(FLUSH_LEN) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // last cycle of the window
    assign done = active && (cnt == CW'(FLUSH_LEN - 1));

endmodule

// File: rtl/acq_run_flags.sv
module acq_run_flags
    import acq_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_idle,
    input  logic      start_loop,
    input  logic      start_once,
    input  logic      stop,
    input  logic      pause,
    input  logic      resume,
    input  logic      mode_in,
    output logic      loop_q,
    output logic      pause_q,
    output acq_mode_t mode_q
);
    logic start_ok;

    assign start_ok = in_idle && (start_loop || start_once) && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            loop_q  <= 1'b0;
            pause_q <= 1'b0;
            mode_q  <= MODE_COLLIDER;
        end else begin
            if (stop) begin
                loop_q <= 1'b0;
            end else if (start_ok) begin
                loop_q <= start_loop;
            end

            if (pause) begin
                pause_q <= 1'b1;
            end else if (resume) begin
                pause_q <= 1'b0;
            end

            if (start_ok) begin
                mode_q <= acq_mode_t'(mode_in);
            end
        end
    end

endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
    import acq_seq_pkg::*;
#(
    parameter int FLUSH_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_trig,
    input  logic pp_en,
    input  logic beam_on,
    input  logic cmd_start_loop,
    input  logic cmd_start_once,
    input  logic cmd_stop,
    input  logic cmd_pause,
    input  logic cmd_resume,
    input  logic trig_pulse,
    input  logic mem_full,
    input  logic ro_done,
    output logic fe_start,
    output logic fe_memfull,
    output logic fe_readout,
    output logic fe_flush,
    output logic busy,
    output logic acquiring
);
    acq_state_t state, next;
    acq_mode_t  mode_q;
    logic       loop_q, pause_q;
    logic       flush_done;
    logic       gate_ok;
    logic       freeze;
    acq_state_t end_of_cycle;

    acq_run_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .in_idle    (state == ST_IDLE),
        .start_loop (cmd_start_loop),
        .start_once (cmd_start_once),
        .stop       (cmd_stop),
        .pause      (cmd_pause),
        .resume     (cmd_resume),
        .mode_in    (mode_trig),
        .loop_q     (loop_q),
        .pause_q    (pause_q),
        .mode_q     (mode_q)
    );

    acq_flush_timer #(.FLUSH_LEN(FLUSH_LEN)) u_flush (
        .clk    (clk),
        .rst    (rst),
        .active (state == ST_FLUSH),
        .done   (flush_done)
    );

    assign gate_ok      = !pp_en || beam_on;
    assign freeze       = (state != ST_IDLE) && (mode_q == MODE_COLLIDER) && pause_q;
    assign end_of_cycle = loop_q ? ST_START : ST_IDLE;

    // next-state logic
    always_comb begin
        next = state;
        if (cmd_stop) begin
            next = ST_IDLE;
        end else if (!freeze) begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start_loop || cmd_start_once) next = ST_START;
                end
                ST_START: begin
                    if (gate_ok) next = ST_ACQ;
                end
                ST_ACQ: begin
                    if (gate_ok) begin
                        if (mode_q == MODE_TRIGGERED) begin
                            if (trig_pulse) next = ST_TRIG;
                        end else begin
                            if (mem_full) next = ST_MFULL;
                        end
                    end
                end
                ST_TRIG:  next = ST_MFULL;
                ST_MFULL: next = ST_READOUT;
                ST_READOUT: begin
                    if (ro_done) begin
                        next = (mode_q == MODE_TRIGGERED) ? ST_FLUSH : end_of_cycle;
                    end
                end
                ST_FLUSH: begin
                    if (flush_done) next = end_of_cycle;
                end
                default: next = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next;
    end

    // outputs: strobes fire in the first cycle of the entered state
    always_ff @(posedge clk) begin
        if (rst) begin
            fe_start   <= 1'b0;
            fe_memfull <= 1'b0;
            fe_readout <= 1'b0;
            fe_flush   <= 1'b0;
        end else begin
            fe_start   <= (state == ST_START)   && (next == ST_ACQ);
            fe_memfull <= (state != ST_MFULL)   && (next == ST_MFULL);
            fe_readout <= (state != ST_READOUT) && (next == ST_READOUT);
            fe_flush   <= (state != ST_FLUSH)   && (next == ST_FLUSH);
        end
    end

    assign busy      = (state != ST_IDLE);
    assign acquiring = (state == ST_ACQ) && gate_ok && !freeze;

endmodule

// File: rtl/acq_seq_checks.sv
module acq_seq_checks
    import acq_seq_pkg::*;
#(
    parameter int FLUSH_LEN = 16
) (
    input logic       clk,
    input logic       rst,
    input acq_state_t state,
    input acq_mode_t  mode_q,
    input logic       loop_q,
    input logic       pause_q,
    input logic       cmd_stop,
    input logic       ro_done,
    input logic       pp_en,
    input logic       beam_on,
    input logic       fe_start,
    input logic       fe_memfull,
    input logic       fe_readout,
    input logic       fe_flush,
    input logic       busy,
    input logic       acquiring
);
    localparam int RW = $clog2(FLUSH_LEN + 1) + 1;

    logic [RW-1:0] flush_run;

    always_ff @(posedge clk) begin
        if (rst)                    flush_run <= '0;
        else if (state == ST_FLUSH) flush_run <= flush_run + 1'b1;
        else                        flush_run <= '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !loop_q && !pause_q && !fe_start && !fe_flush));

    assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fe_start, fe_memfull, fe_readout, fe_flush}));

    assert_trig_to_mfull_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRIG && !cmd_stop) |=> fe_memfull);

    assert_no_flush_collider_R3: assert property (@(posedge clk) disable iff (rst)
        fe_flush |-> (mode_q == MODE_TRIGGERED));

    assert_stop_idle_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> !busy);

    assert_pause_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == MODE_COLLIDER && pause_q && !cmd_stop) |=> $stable(state));

    assert_beam_gate_R8: assert property (@(posedge clk) disable iff (rst)
        acquiring |-> (beam_on || !pp_en));

    assert_readout_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READOUT && !ro_done && !cmd_stop) |=> (state == ST_READOUT));

    assert_flush_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH) |-> (flush_run < RW'(FLUSH_LEN)));

    assert_flush_len_R11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FLUSH && flush_run != '0 && !$past(cmd_stop))
            |-> (flush_run == RW'(FLUSH_LEN)));

endmodule

bind acq_seq_ctrl acq_seq_checks #(.FLUSH_LEN(FLUSH_LEN)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .mode_q     (mode_q),
    .loop_q     (loop_q),
    .pause_q    (pause_q),
    .cmd_stop   (cmd_stop),
    .ro_done    (ro_done),
    .pp_en      (pp_en),
    .beam_on    (beam_on),
    .fe_start   (fe_start),
    .fe_memfull (fe_memfull),
    .fe_readout (fe_readout),
    .fe_flush   (fe_flush),
    .busy       (busy),
    .acquiring  (acquiring)
);

// File: tb/acq_seq_ctrl_tb.sv
module acq_seq_ctrl_tb;

    localparam int FLUSH_LEN = 16;
    // strobe codes: bit0 start, bit1 memfull, bit2 readout, bit3 flush
    localparam int S_ST = 1, S_MF = 2, S_RO = 4, S_FL = 8;
    // pulse vector bits
    localparam int P_LOOP = 0, P_ONCE = 1, P_STOP = 2, P_PAUSE = 3,
                   P_RESUME = 4, P_TRIG = 5, P_MFULL = 6, P_DONE = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_trig, pp_en, beam_on;
    logic [7:0] pv;
    logic       fe_start, fe_memfull, fe_readout, fe_flush, busy, acquiring;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    acq_seq_ctrl #(.FLUSH_LEN(FLUSH_LEN)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .mode_trig      (mode_trig),
        .pp_en          (pp_en),
        .beam_on        (beam_on),
        .cmd_start_loop (pv[P_LOOP]),
        .cmd_start_once (pv[P_ONCE]),
        .cmd_stop       (pv[P_STOP]),
        .cmd_pause      (pv[P_PAUSE]),
        .cmd_resume     (pv[P_RESUME]),
        .trig_pulse     (pv[P_TRIG]),
        .mem_full       (pv[P_MFULL]),
        .ro_done        (pv[P_DONE]),
        .fe_start       (fe_start),
        .fe_memfull     (fe_memfull),
        .fe_readout     (fe_readout),
        .fe_flush       (fe_flush),
        .busy           (busy),
        .acquiring      (acquiring)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int b);
        pv[b] = 1'b1;
        @(negedge clk);
        pv = '0;
    endtask

    task automatic expect_strobe(input int code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    // monitor: compares every strobe against the scoreboard queue
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            logic [3:0] s;
            s = {fe_flush, fe_readout, fe_memfull, fe_start};
            if (s != 4'd0) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected strobe", int'(s), 0);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, int'(s), e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; pv = '0; mode_trig = 1'b1; pp_en = 1'b0; beam_on = 1'b0;
        tick(3);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 strobes in reset", int'({fe_flush, fe_readout, fe_memfull, fe_start}), 0);
        chk("R1 acquiring in reset", int'(acquiring), 0);
        rst = 1'b0;
        tick(1);

        // triggered single cycle
        expect_strobe(S_ST, "R2 start"); expect_strobe(S_MF, "R2 memfull");
        expect_strobe(S_RO, "R2 readout"); expect_strobe(S_FL, "R2 flush");
        pulse(P_ONCE); tick(1);
        chk("R2 acquiring", int'(acquiring), 1);
        pulse(P_TRIG); tick(2);
        tick(3);
        chk("R10 held in readout", int'(busy), 1);
        pulse(P_DONE);
        n = 0;
        while (busy && n < 100) begin n++; tick(1); end
        chk("R11 flush length", n, FLUSH_LEN);
        chk("R5 once parks idle", int'(busy), 0);

        // mem_full ignored in triggered mode
        expect_strobe(S_ST, "R4 start");
        pulse(P_ONCE); tick(1);
        pulse(P_MFULL); tick(2);
        chk("R4 memfull ignored", int'(acquiring), 1);
        pulse(P_STOP);
        chk("R6 stop from acq", int'(busy), 0);

        // collider looping
        mode_trig = 1'b0;
        expect_strobe(S_ST, "R3 start"); expect_strobe(S_MF, "R3 memfull");
        expect_strobe(S_RO, "R3 readout"); expect_strobe(S_ST, "R5 loop restart");
        expect_strobe(S_MF, "R3 memfull 2"); expect_strobe(S_RO, "R3 readout 2");
        expect_strobe(S_ST, "R5 loop restart 2");
        pulse(P_LOOP); tick(1);
        pulse(P_TRIG); tick(2);
        chk("R3 trigger ignored", int'(acquiring), 1);
        pulse(P_MFULL); tick(1);
        pulse(P_DONE); tick(1);
        chk("R5 loop acquiring", int'(acquiring), 1);
        pulse(P_MFULL); tick(1);
        pulse(P_DONE); tick(1);
        chk("R5 loop again", int'(acquiring), 1);
        pulse(P_STOP);
        chk("R6 stop loop", int'(busy), 0);
        tick(3);
        chk("R6 stays idle", int'(busy), 0);

        // pause in collider mode
        expect_strobe(S_ST, "R7 start");
        pulse(P_ONCE); tick(1);
        pulse(P_PAUSE);
        chk("R7 frozen acquiring", int'(acquiring), 0);
        chk("R7 frozen busy", int'(busy), 1);
        pulse(P_MFULL); tick(2);
        chk("R7 memfull ignored while paused", int'(acquiring), 0);
        pulse(P_RESUME);
        chk("R7 resumed", int'(acquiring), 1);
        expect_strobe(S_MF, "R7 memfull"); expect_strobe(S_RO, "R7 readout");
        pulse(P_MFULL); tick(1);
        pulse(P_DONE);
        chk("R3 collider ends without flush", int'(busy), 0);

        // pause has no effect in triggered mode
        mode_trig = 1'b1;
        pulse(P_PAUSE);
        expect_strobe(S_ST, "R7 trig start"); expect_strobe(S_MF, "R7 trig memfull");
        expect_strobe(S_RO, "R7 trig readout"); expect_strobe(S_FL, "R7 trig flush");
        pulse(P_ONCE); tick(1);
        chk("R7 pause no effect", int'(acquiring), 1);
        pulse(P_TRIG); tick(2);
        pulse(P_DONE); tick(FLUSH_LEN);
        chk("R7 trig cycle done", int'(busy), 0);
        pulse(P_RESUME);

        // mode sampled only at start
        expect_strobe(S_ST, "R9 start");
        pulse(P_ONCE); tick(1);
        mode_trig = 1'b0;
        pulse(P_MFULL); tick(2);
        chk("R9 mode kept", int'(acquiring), 1);
        expect_strobe(S_MF, "R9 memfull"); expect_strobe(S_RO, "R9 readout");
        expect_strobe(S_FL, "R9 flush");
        pulse(P_TRIG); tick(2);
        pulse(P_DONE); tick(FLUSH_LEN);
        chk("R9 cycle done", int'(busy), 0);

        // beam gating
        mode_trig = 1'b1; pp_en = 1'b1; beam_on = 1'b0;
        pulse(P_ONCE); tick(3);
        chk("R8 waits for beam busy", int'(busy), 1);
        chk("R8 waits for beam acq", int'(acquiring), 0);
        expect_strobe(S_ST, "R8 start");
        beam_on = 1'b1; tick(1);
        chk("R8 beam on", int'(acquiring), 1);
        beam_on = 1'b0; tick(1);
        chk("R8 beam off", int'(acquiring), 0);
        pulse(P_TRIG); tick(2);
        chk("R8 trigger ignored busy", int'(busy), 1);
        beam_on = 1'b1; tick(1);
        chk("R8 trigger ignored acq", int'(acquiring), 1);
        pulse(P_STOP);
        pp_en = 1'b0;

        // readout hold and stop inside readout
        mode_trig = 1'b0;
        expect_strobe(S_ST, "R10 start"); expect_strobe(S_MF, "R10 memfull");
        expect_strobe(S_RO, "R10 readout");
        pulse(P_ONCE); tick(1);
        pulse(P_MFULL); tick(1);
        tick(10);
        chk("R10 waits for done", int'(busy), 1);
        pulse(P_STOP);
        chk("R6 stop in readout", int'(busy), 0);
        tick(3);

        // reset clears pause
        pulse(P_PAUSE);
        pulse(P_LOOP); tick(3);
        chk("R7 paused at start", int'(busy), 1);
        chk("R7 paused no acq", int'(acquiring), 0);
        rst = 1'b1; tick(1); rst = 1'b0;
        chk("R1 reset to idle", int'(busy), 0);
        expect_strobe(S_ST, "R1 start"); expect_strobe(S_MF, "R1 memfull");
        expect_strobe(S_RO, "R1 readout");
        pulse(P_ONCE); tick(1);
        chk("R1 pause cleared", int'(acquiring), 1);
        pulse(P_MFULL); tick(1);
        pulse(P_DONE);
        chk("R1 cycle ends", int'(busy), 0);

        tick(5);
        chk("R12 all strobes seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule